// File: doc/BRIEF.md
# Pointer Load/Store Address Generator

This block forms the data-memory address for every load and store of an 8-bit processor core. Three 16-bit pointers, each held in a pair of adjacent general registers, reach the block on one packed bus. The decoder supplies four things: an addressing mode, a pointer select, a 6-bit unsigned displacement and a 16-bit direct address. One cycle after a request, the block presents the effective address with a single strobe: data read, data write or program-memory read. In the same cycle it presents any updated pointer value, with a write-back enable and the index of the pointer to update.

The block also keeps the stack pointer. A push writes at the current stack pointer and then moves it down. A pop moves it up first and reads there. Program-memory reads always address through the third pointer. Their implied-destination form redirects the result to register 0. Illegal combinations raise a one-cycle reject flag and cause no access and no write-back. No processor status flag is produced for any of these operations.

The control is a two-state machine. ST_IDLE goes to ST_ISSUE on a request (transition T_ACCEPT) and stays in ST_IDLE without one (T_WAIT). ST_ISSUE stays in ST_ISSUE on a back-to-back request (T_CHAIN) and returns to ST_IDLE otherwise (T_DRAIN). Outputs are captured as the machine enters or re-enters ST_ISSUE.

Top module: `ptr_agu`

## Requirements
- R1: After reset all strobes, the write-back enable and the reject flag are low, and the stack pointer holds 16'h045F, so the first push addresses 16'h045F.
- R2: Mode 0 (plain indirect) addresses the pointer chosen by ptr_sel (0 = X in ptr_regs[15:0], 1 = Y in [31:16], 2 = Z in [47:32]) without write-back; is_store = 1 gives a data write, 0 a data read.
- R3: Mode 1 (post-increment) addresses the current pointer value and writes back that value plus one modulo 2^16 to the selected pointer.
- R4: Mode 2 (pre-decrement) addresses the pointer minus one modulo 2^16 and writes back that same value.
- R5: Mode 3 (displacement) addresses Y or Z plus the zero-extended 6-bit disp, modulo 2^16, and never writes back.
- R6: Displacement with X, any access with ptr_sel = 3 in modes 0 to 3, and mode codes 10 to 15 are rejected: bad_req pulses and no strobe or write-back occurs.
- R7: Mode 4 (direct) addresses dir_addr, ignores ptr_sel and never writes back.
- R8: Modes 5, 6 and 7 read program memory at Z whatever ptr_sel and is_store are; mode 7 writes back Z plus one to pointer index 2, and mode 5 forces dst_out to 0.
- R9: Mode 8 (push) writes at the stack pointer and then decrements it. Mode 9 (pop) increments it and then reads at the new value. Other modes leave it unchanged.
- R10: Results appear exactly one cycle after req and last one cycle; at most one of dmem_rd, dmem_wr, pmem_rd, bad_req is high.
- R11: For all modes other than 5, dst_out repeats dst_reg as it was with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid this cycle |
| mode | input | 4 | Addressing mode code |
| ptr_sel | input | 2 | Pointer select (0 X, 1 Y, 2 Z) |
| is_store | input | 1 | 1 = store, 0 = load for data modes |
| disp | input | 6 | Unsigned displacement |
| dir_addr | input | 16 | Direct address from the instruction |
| dst_reg | input | 5 | Destination register index |
| ptr_regs | input | 48 | Three pointers, X lowest |
| acc_addr | output | 16 | Effective address |
| dmem_rd | output | 1 | Data-memory read strobe |
| dmem_wr | output | 1 | Data-memory write strobe |
| pmem_rd | output | 1 | Program-memory read strobe |
| ptr_wb_en | output | 1 | Pointer write-back enable |
| ptr_wb_sel | output | 2 | Pointer index to update |
| ptr_wb_val | output | 16 | New pointer value |
| dst_out | output | 5 | Destination register for the loaded byte |
| bad_req | output | 1 | Illegal request rejected |

## Verification
Each mode is tried with pointer values at the wrap points (16'hFFFF for increment, 16'h0000 for decrement, 16'hFFFE with a displacement) and at ordinary mid-range values. This separates correct modulo arithmetic from mistakes in the carry or the borrow. The two pointers that are not addressed hold distinct filler values. A wrong pointer select therefore shows up as a wrong address, and in the program-read and direct cases this reveals whether ptr_sel is wrongly used. Push and pop sequences, and stack activity spaced apart by other modes, distinguish decrement-after from decrement-before and show that other modes leave the stack pointer alone.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

    typedef enum logic [3:0] {
        AM_IND     = 4'd0,
        AM_INC     = 4'd1,
        AM_DEC     = 4'd2,
        AM_DISP    = 4'd3,
        AM_DIRECT  = 4'd4,
        AM_PGM_R0  = 4'd5,
        AM_PGM     = 4'd6,
        AM_PGM_INC = 4'd7,
        AM_PUSH    = 4'd8,
        AM_POP     = 4'd9
    } amode_e;

    typedef enum logic [1:0] {
        PS_X    = 2'd0,
        PS_Y    = 2'd1,
        PS_Z    = 2'd2,
        PS_NONE = 2'd3
    } psel_e;

    typedef enum logic [1:0] {
        AK_LOAD  = 2'd0,
        AK_STORE = 2'd1,
        AK_PROG  = 2'd2,
        AK_BAD   = 2'd3
    } acc_kind_e;

    localparam int PTR_COUNT = 3;
    localparam int SEL_W     = 2;

endpackage

// File: rtl/ptr_agu_ea.sv
module ptr_agu_ea
    import ptr_agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 6
) (
    input  logic [3:0]                  mode,
    input  logic [SEL_W-1:0]            sel,
    input  logic                        is_store,
    input  logic [DISP_W-1:0]           disp,
    input  logic [ADDR_W-1:0]           dir_addr,
    input  logic [PTR_COUNT*ADDR_W-1:0] ptr_regs,
    input  logic [ADDR_W-1:0]           sp_cur,
    output logic [ADDR_W-1:0]           ea,
    output acc_kind_e                   kind,
    output logic                        wb_en,
    output logic [SEL_W-1:0]            wb_sel,
    output logic [ADDR_W-1:0]           wb_val,
    output logic                        push_hit,
    output logic                        pop_hit
);

    localparam int PAD_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] ptr_arr [PTR_COUNT];

    for (genvar g = 0; g < PTR_COUNT; g++) begin : g_unpack
        assign ptr_arr[g] = ptr_regs[g*ADDR_W +: ADDR_W];
    end

    psel_e             eff_sel;
    logic              sel_ok;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] base_inc;
    logic [ADDR_W-1:0] base_dec;
    logic [ADDR_W-1:0] base_dsp;
    acc_kind_e         data_kind;
    logic              is_pgm;

    always_comb begin
        is_pgm  = (mode == AM_PGM_R0) || (mode == AM_PGM) || (mode == AM_PGM_INC);
        eff_sel = is_pgm ? PS_Z : psel_e'(sel);
        sel_ok  = 1'b1;
        unique case (eff_sel)
            PS_X:    base = ptr_arr[0];
            PS_Y:    base = ptr_arr[1];
            PS_Z:    base = ptr_arr[2];
            default: begin
                base   = '0;
                sel_ok = 1'b0;
            end
        endcase
        base_inc  = base + 1'b1;
        base_dec  = base - 1'b1;
        base_dsp  = base + {{PAD_W{1'b0}}, disp};
        data_kind = is_store ? AK_STORE : AK_LOAD;
    end

    always_comb begin
        ea       = base;
        kind     = AK_BAD;
        wb_en    = 1'b0;
        wb_sel   = eff_sel;
        wb_val   = base;
        push_hit = 1'b0;
        pop_hit  = 1'b0;
        case (mode)
            AM_IND: begin
                if (sel_ok) kind = data_kind;
            end
            AM_INC: begin
                if (sel_ok) begin
                    kind   = data_kind;
                    wb_en  = 1'b1;
                    wb_val = base_inc;
                end
            end
            AM_DEC: begin
                if (sel_ok) begin
                    kind   = data_kind;
                    ea     = base_dec;
                    wb_en  = 1'b1;
                    wb_val = base_dec;
                end
            end
            AM_DISP: begin
                if (sel_ok && (eff_sel != PS_X)) begin
                    kind = data_kind;
                    ea   = base_dsp;
                end
            end
            AM_DIRECT: begin
                kind = data_kind;
                ea   = dir_addr;
            end
            AM_PGM_R0, AM_PGM: begin
                kind = AK_PROG;
            end
            AM_PGM_INC: begin
                kind   = AK_PROG;
                wb_en  = 1'b1;
                wb_val = base_inc;
            end
            AM_PUSH: begin
                kind     = AK_STORE;
                ea       = sp_cur;
                push_hit = 1'b1;
            end
            AM_POP: begin
                kind    = AK_LOAD;
                ea      = sp_cur + 1'b1;
                pop_hit = 1'b1;
            end
            default: kind = AK_BAD;
        endcase
    end

endmodule

// File: rtl/ptr_agu_sp.sv
module ptr_agu_sp #(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] SP_INIT = 16'h045F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic              pop_en,
    output logic [ADDR_W-1:0] sp_q
);

    localparam logic [ADDR_W-1:0] SP_RST = ADDR_W'(SP_INIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= SP_RST;
        end else if (push_en) begin
            sp_q <= sp_q - 1'b1;
        end else if (pop_en) begin
            sp_q <= sp_q + 1'b1;
        end
    end

    AST_SP_PUSH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> (sp_q == ADDR_W'($past(sp_q) - 1'b1))); // R9
    AST_SP_POP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en) |=> (sp_q == ADDR_W'($past(sp_q) + 1'b1))); // R9
    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_en && !pop_en) |=> $stable(sp_q)); // R9

endmodule

// File: rtl/ptr_agu_ctrl.sv
module ptr_agu_ctrl
    import ptr_agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              force_r0,
    input  logic [REG_W-1:0]  dst_reg,
    input  logic [ADDR_W-1:0] ea,
    input  acc_kind_e         kind,
    input  logic              wb_en_c,
    input  logic [SEL_W-1:0]  wb_sel_c,
    input  logic [ADDR_W-1:0] wb_val_c,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              dmem_rd,
    output logic              dmem_wr,
    output logic              pmem_rd,
    output logic              ptr_wb_en,
    output logic [SEL_W-1:0]  ptr_wb_sel,
    output logic [ADDR_W-1:0] ptr_wb_val,
    output logic [REG_W-1:0]  dst_out,
    output logic              bad_req
);

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } st_e;

    st_e state_q;
    st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = req ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = req ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_addr   <= '0;
            dmem_rd    <= 1'b0;
            dmem_wr    <= 1'b0;
            pmem_rd    <= 1'b0;
            ptr_wb_en  <= 1'b0;
            ptr_wb_sel <= '0;
            ptr_wb_val <= '0;
            dst_out    <= '0;
            bad_req    <= 1'b0;
        end else if (state_d == ST_ISSUE) begin
            acc_addr   <= ea;
            dmem_rd    <= (kind == AK_LOAD);
            dmem_wr    <= (kind == AK_STORE);
            pmem_rd    <= (kind == AK_PROG);
            bad_req    <= (kind == AK_BAD);
            ptr_wb_en  <= wb_en_c && (kind != AK_BAD);
            ptr_wb_sel <= wb_sel_c;
            ptr_wb_val <= wb_val_c;
            dst_out    <= force_r0 ? '0 : dst_reg;
        end else begin
            dmem_rd    <= 1'b0;
            dmem_wr    <= 1'b0;
            pmem_rd    <= 1'b0;
            bad_req    <= 1'b0;
            ptr_wb_en  <= 1'b0;
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dmem_rd, dmem_wr, pmem_rd, bad_req})); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !(dmem_rd || dmem_wr || pmem_rd || ptr_wb_en || bad_req)); // R10
    AST_WB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wb_en |-> ((ptr_wb_val == acc_addr) || (ptr_wb_val == ADDR_W'(acc_addr + 1'b1)))); // R3
    AST_WB_WITH_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wb_en |-> (dmem_rd || dmem_wr || pmem_rd)); // R4
    AST_BAD_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |-> !ptr_wb_en); // R6

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
    import ptr_agu_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          DISP_W  = 6,
    parameter int          REG_W   = 5,
    parameter logic [15:0] SP_INIT = 16'h045F
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic [3:0]                  mode,
    input  logic [1:0]                  ptr_sel,
    input  logic                        is_store,
    input  logic [DISP_W-1:0]           disp,
    input  logic [ADDR_W-1:0]           dir_addr,
    input  logic [REG_W-1:0]            dst_reg,
    input  logic [PTR_COUNT*ADDR_W-1:0] ptr_regs,
    output logic [ADDR_W-1:0]           acc_addr,
    output logic                        dmem_rd,
    output logic                        dmem_wr,
    output logic                        pmem_rd,
    output logic                        ptr_wb_en,
    output logic [1:0]                  ptr_wb_sel,
    output logic [ADDR_W-1:0]           ptr_wb_val,
    output logic [REG_W-1:0]            dst_out,
    output logic                        bad_req
);

    logic [ADDR_W-1:0] sp_cur;
    logic [ADDR_W-1:0] ea_c;
    acc_kind_e         kind_c;
    logic              wb_en_c;
    logic [SEL_W-1:0]  wb_sel_c;
    logic [ADDR_W-1:0] wb_val_c;
    logic              push_hit;
    logic              pop_hit;
    logic              push_en;
    logic              pop_en;
    logic              force_r0;

    assign push_en  = req && push_hit;
    assign pop_en   = req && pop_hit;
    assign force_r0 = (mode == AM_PGM_R0);

    ptr_agu_ea #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_ea (
        .mode     (mode),
        .sel      (ptr_sel),
        .is_store (is_store),
        .disp     (disp),
        .dir_addr (dir_addr),
        .ptr_regs (ptr_regs),
        .sp_cur   (sp_cur),
        .ea       (ea_c),
        .kind     (kind_c),
        .wb_en    (wb_en_c),
        .wb_sel   (wb_sel_c),
        .wb_val   (wb_val_c),
        .push_hit (push_hit),
        .pop_hit  (pop_hit)
    );

    ptr_agu_sp #(
        .ADDR_W  (ADDR_W),
        .SP_INIT (SP_INIT)
    ) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_en (push_en),
        .pop_en  (pop_en),
        .sp_q    (sp_cur)
    );

    ptr_agu_ctrl #(
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .force_r0   (force_r0),
        .dst_reg    (dst_reg),
        .ea         (ea_c),
        .kind       (kind_c),
        .wb_en_c    (wb_en_c),
        .wb_sel_c   (wb_sel_c),
        .wb_val_c   (wb_val_c),
        .acc_addr   (acc_addr),
        .dmem_rd    (dmem_rd),
        .dmem_wr    (dmem_wr),
        .pmem_rd    (pmem_rd),
        .ptr_wb_en  (ptr_wb_en),
        .ptr_wb_sel (ptr_wb_sel),
        .ptr_wb_val (ptr_wb_val),
        .dst_out    (dst_out),
        .bad_req    (bad_req)
    );

    AST_NO_X_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (mode == AM_DISP) && (ptr_sel == PS_X)) |=> bad_req); // R6
    AST_PGM_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (mode >= AM_PGM_R0) && (mode <= AM_PGM_INC)) |=> (pmem_rd && !dmem_wr && !dmem_rd)); // R8

endmodule

// File: tb/ptr_agu_bench.sv
module ptr_agu_bench;

    localparam int CLK_P = 10;
    localparam logic [15:0] SP0 = 16'h045F;

    typedef struct packed {
        logic [3:0]  mode;
        logic [1:0]  sel;
        logic        st;
        logic [5:0]  q;
        logic [15:0] ptr;
        logic [15:0] dir;
        logic [15:0] e_addr;
        logic        e_rd;
        logic        e_wr;
        logic        e_prd;
        logic        e_wb;
        logic [15:0] e_wbv;
        logic        e_bad;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  2'd0, 1'b0, 6'd0,  16'h1234, 16'h0000, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0},
        '{4'd0,  2'd2, 1'b1, 6'd0,  16'h0100, 16'h0000, 16'h0100, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0},
        '{4'd1,  2'd1, 1'b0, 6'd0,  16'h2000, 16'h0000, 16'h2000, 1'b1, 1'b0, 1'b0, 1'b1, 16'h2001, 1'b0},
        '{4'd1,  2'd0, 1'b1, 6'd0,  16'hFFFF, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b0},
        '{4'd2,  2'd2, 1'b0, 6'd0,  16'h0000, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF, 1'b0},
        '{4'd2,  2'd0, 1'b1, 6'd0,  16'h0801, 16'h0000, 16'h0800, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0800, 1'b0},
        '{4'd3,  2'd1, 1'b0, 6'd63, 16'h1000, 16'h0000, 16'h103F, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0},
        '{4'd3,  2'd2, 1'b1, 6'd5,  16'hFFFE, 16'h0000, 16'h0003, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0},
        '{4'd3,  2'd0, 1'b0, 6'd4,  16'h1234, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1},
        '{4'd0,  2'd3, 1'b0, 6'd0,  16'h1234, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1},
        '{4'd4,  2'd3, 1'b1, 6'd0,  16'h0000, 16'hBEEF, 16'hBEEF, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0},
        '{4'd4,  2'd1, 1'b0, 6'd0,  16'h0000, 16'h0060, 16'h0060, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0},
        '{4'd7,  2'd0, 1'b0, 6'd0,  16'h0FFF, 16'h0000, 16'h0FFF, 1'b0, 1'b0, 1'b1, 1'b1, 16'h1000, 1'b0},
        '{4'd6,  2'd1, 1'b1, 6'd0,  16'h0042, 16'h0000, 16'h0042, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0},
        '{4'd12, 2'd0, 1'b0, 6'd0,  16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1},
        '{4'd1,  2'd2, 1'b0, 6'd0,  16'h7FFF, 16'h0000, 16'h7FFF, 1'b1, 1'b0, 1'b0, 1'b1, 16'h8000, 1'b0}
    };

    logic        clk;
    logic        rst_n;
    logic        req;
    logic [3:0]  mode;
    logic [1:0]  ptr_sel;
    logic        is_store;
    logic [5:0]  disp;
    logic [15:0] dir_addr;
    logic [4:0]  dst_reg;
    logic [47:0] ptr_regs;
    logic [15:0] acc_addr;
    logic        dmem_rd;
    logic        dmem_wr;
    logic        pmem_rd;
    logic        ptr_wb_en;
    logic [1:0]  ptr_wb_sel;
    logic [15:0] ptr_wb_val;
    logic [4:0]  dst_out;
    logic        bad_req;

    ptr_agu u_ptr_agu (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .mode       (mode),
        .ptr_sel    (ptr_sel),
        .is_store   (is_store),
        .disp       (disp),
        .dir_addr   (dir_addr),
        .dst_reg    (dst_reg),
        .ptr_regs   (ptr_regs),
        .acc_addr   (acc_addr),
        .dmem_rd    (dmem_rd),
        .dmem_wr    (dmem_wr),
        .pmem_rd    (pmem_rd),
        .ptr_wb_en  (ptr_wb_en),
        .ptr_wb_sel (ptr_wb_sel),
        .ptr_wb_val (ptr_wb_val),
        .dst_out    (dst_out),
        .bad_req    (bad_req)
    );

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic quiet_chk(input string tag);
        chk(tag, {27'd0, dmem_rd, dmem_wr, pmem_rd, ptr_wb_en, bad_req}, 32'd0);
    endtask

    task automatic issue(input logic [3:0] m, input logic [1:0] s, input logic st,
                         input logic [5:0] q, input logic [15:0] d, input logic [4:0] dst);
        req      = 1'b1;
        mode     = m;
        ptr_sel  = s;
        is_store = st;
        disp     = q;
        dir_addr = d;
        dst_reg  = dst;
        @(negedge clk);
        req      = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        string tg;
        int    tgt;
        rst_n    = 1'b0;
        req      = 1'b0;
        mode     = '0;
        ptr_sel  = '0;
        is_store = 1'b0;
        disp     = '0;
        dir_addr = '0;
        dst_reg  = '0;
        ptr_regs = {16'hC0C0, 16'hB0B0, 16'hA0A0};
        repeat (3) @(negedge clk);
        quiet_chk("R1 reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        quiet_chk("R1 idle after reset");

        // R9 / R1: stack sequence from reset value
        issue(4'd8, 2'd0, 1'b0, 6'd0, 16'h0, 5'd3);
        chk("R1 first push address", acc_addr, SP0);
        chk("R9 push is write", {dmem_wr, dmem_rd}, 2'b10);
        issue(4'd8, 2'd0, 1'b0, 6'd0, 16'h0, 5'd3);
        chk("R9 second push address", acc_addr, SP0 - 16'd1);
        issue(4'd9, 2'd0, 1'b1, 6'd0, 16'h0, 5'd4);
        chk("R9 pop address", acc_addr, SP0 - 16'd1);
        chk("R9 pop is read", {dmem_wr, dmem_rd}, 2'b01);
        chk("R11 pop destination", dst_out, 5'd4);
        issue(4'd9, 2'd0, 1'b0, 6'd0, 16'h0, 5'd4);
        chk("R9 second pop address", acc_addr, SP0);
        @(negedge clk);
        quiet_chk("R10 single-cycle result");

        // vector table
        for (int i = 0; i < NV; i++) begin
            ptr_regs = {16'hC0C0, 16'hB0B0, 16'hA0A0};
            tgt = (VECS[i].mode >= 4'd5 && VECS[i].mode <= 4'd7) ? 2 : int'(VECS[i].sel);
            if (tgt < 3) ptr_regs[tgt*16 +: 16] = VECS[i].ptr;
            case (VECS[i].mode)
                4'd0:    tg = "R2";
                4'd1:    tg = "R3";
                4'd2:    tg = "R4";
                4'd3:    tg = "R5";
                4'd4:    tg = "R7";
                4'd5, 4'd6, 4'd7: tg = "R8";
                default: tg = "R6";
            endcase
            if (VECS[i].e_bad) tg = "R6";
            issue(VECS[i].mode, VECS[i].sel, VECS[i].st, VECS[i].q, VECS[i].dir, 5'd9);
            chk($sformatf("%s vec %0d strobes", tg, i),
                {27'd0, dmem_rd, dmem_wr, pmem_rd, ptr_wb_en, bad_req},
                {27'd0, VECS[i].e_rd, VECS[i].e_wr, VECS[i].e_prd, VECS[i].e_wb, VECS[i].e_bad});
            if (!VECS[i].e_bad)
                chk($sformatf("%s vec %0d address", tg, i), acc_addr, VECS[i].e_addr);
            if (VECS[i].e_wb) begin
                chk($sformatf("%s vec %0d wb value", tg, i), ptr_wb_val, VECS[i].e_wbv);
                chk($sformatf("%s vec %0d wb pointer", tg, i), ptr_wb_sel, tgt);
            end
        end

        // R8: implied-destination program read goes to register 0
        ptr_regs = {16'h3456, 16'hB0B0, 16'hA0A0};
        issue(4'd5, 2'd1, 1'b1, 6'd0, 16'h0, 5'd7);
        chk("R8 implied form address", acc_addr, 16'h3456);
        chk("R8 implied form destination", dst_out, 5'd0);
        chk("R8 implied form no write-back", ptr_wb_en, 1'b0);
        issue(4'd6, 2'd0, 1'b0, 6'd0, 16'h0, 5'd7);
        chk("R11 program read keeps destination", dst_out, 5'd7);
        issue(4'd0, 2'd1, 1'b0, 6'd0, 16'h0, 5'd22);
        chk("R11 load destination", dst_out, 5'd22);
        @(negedge clk);
        quiet_chk("R10 cleared after last request");

        // R9: non-stack traffic left stack pointer at reset value
        issue(4'd8, 2'd0, 1'b0, 6'd0, 16'h0, 5'd0);
        chk("R9 stack untouched by other modes", acc_addr, SP0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule